// File: doc/BRIEF.md
# Dual Time-of-Day Alarm and Interrupt Pin Controller

This block watches a running calendar time and raises a sticky flag whenever one of two programmable alarm settings matches it. Each alarm is compared field by field (seconds, minutes, hours, day) against the current BCD time. The comparison is taken only on the cycle that carries the once-per-second update strobe. A flag that has been set stays set until the host clears it. The host clears a flag by writing 0 to its bit in the status register. Writing 1 to a flag bit never sets it and never disturbs it.

One open-drain style output pin serves two purposes, and the interrupt-control bit chooses between them. In interrupt mode the pin is pulled low while any alarm has both its flag and its enable bit set. In square-wave mode the pin carries a clock derived from a reference tick that runs at twice 32.768 kHz. A two-bit rate field selects one of four frequencies. The block sits beside the timekeeping counters and the bus register file. It takes their values as plain inputs and returns the flags and the pin level.

Top module: `alm_ctl`

## Requirements
- R1: During and right after synchronous reset both flags read 0, and the square-wave divider count is 0. With interrupt mode selected and no flag set, the pin reads 1.
- R2: A sec_tick_i cycle in which all four fields of alarm 1 equal now_i sets flag_o[0] at that clock edge. If any single field differs, the flag is not set.
- R3: Alarm 2 works the same way on flag_o[1], and neither alarm's match affects the other alarm's flag.
- R4: Equal fields without sec_tick_i never set a flag.
- R5: A status write with bit i equal to 0 clears flag i at that edge. A write with bit i equal to 1 leaves flag i unchanged, whether it was 0 or 1.
- R6: If a set event and a clearing write fall on the same edge, the flag ends up set.
- R7: A set flag stays set across later second ticks that do not match, until it is cleared.
- R8: With intcn_i = 1 the pin reads 0 exactly when some i has flag_o[i] = 1 and alm_ie_i[i] = 1. Otherwise it reads 1.
- R9: With intcn_i = 0 the pin equals one bit of a 16-bit count of ref_tick_i cycles. The bit is chosen by rate_i: 00 selects bit 15 (1 Hz), 01 selects bit 3 (4.096 kHz), 10 selects bit 2 (8.192 kHz) and 11 selects bit 0 (32.768 kHz). In this mode the flags and enables have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick_i | input | 1 | One-cycle strobe on each seconds update |
| ref_tick_i | input | 1 | Reference tick at 65.536 kHz that advances the divider |
| now_i | input | 32 | Current time, BCD {day, hour, min, sec}, 8 bits each |
| alm1_i | input | 32 | Alarm 1 setting, same layout as now_i |
| alm2_i | input | 32 | Alarm 2 setting, same layout as now_i |
| alm_ie_i | input | 2 | Per-alarm interrupt enable (bit 0 = alarm 1) |
| intcn_i | input | 1 | 1 = interrupt mode on the pin, 0 = square-wave mode |
| rate_i | input | 2 | Square-wave rate select |
| stat_wr_i | input | 1 | Host write strobe to the status flags |
| stat_wdata_i | input | 2 | Write data for the flags (0 clears, 1 keeps) |
| flag_o | output | 2 | Sticky alarm flags (bit 0 = alarm 1) |
| pin_o | output | 1 | Shared pin level, 0 = driven low, 1 = released |

## Verification
Two things can land on the same clock edge: a second tick whose time matches an alarm, and a host write that clears that alarm's flag. The bench forces this by raising sec_tick_i and the clearing write on the same cycle, once with the flag already set and once with it clear. After that edge the flag must read 1 in both cases. In the same test the other flag, whose alarm does not match, must read 0, because the write clears it.

// File: rtl/alm_ctl_pkg.sv
package alm_ctl_pkg;

    localparam int FIELD_W  = 8;
    localparam int N_FIELDS = 4;
    localparam int TIME_W   = FIELD_W * N_FIELDS;
    localparam int N_ALARMS = 2;

    typedef struct packed {
        logic [FIELD_W-1:0] day;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
    } tod_t;

    typedef enum logic [1:0] {
        RATE_1HZ = 2'b00,
        RATE_4K  = 2'b01,
        RATE_8K  = 2'b10,
        RATE_32K = 2'b11
    } sqw_rate_e;

    // Divider bit that carries the chosen frequency; the reference runs
    // at 2^div_w Hz, so bit k toggles at 2^(div_w-1-k) Hz.
    function automatic int unsigned rate_bit(sqw_rate_e r, int unsigned div_w);
        int unsigned b;
        case (r)
            RATE_1HZ: b = div_w - 1;
            RATE_4K:  b = div_w - 13;
            RATE_8K:  b = div_w - 14;
            default:  b = div_w - 16;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/alm_match.sv
module alm_match
    import alm_ctl_pkg::*;
(
    input  tod_t now_i,
    input  tod_t alarm_i,
    output logic hit_o
);
    logic [TIME_W-1:0]   now_v;
    logic [TIME_W-1:0]   alm_v;
    logic [N_FIELDS-1:0] field_eq;

    assign now_v = now_i;
    assign alm_v = alarm_i;

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        assign field_eq[f] = (now_v[f*FIELD_W +: FIELD_W] == alm_v[f*FIELD_W +: FIELD_W]);
    end

    assign hit_o = &field_eq;
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // set wins over clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= set_i | (flag_q & ~clr_i);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sqw_div.sv
module sqw_div
    import alm_ctl_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step_i,
    input  sqw_rate_e  rate_i,
    output logic       wave_o
);
    localparam int IDX_W = $clog2(DIV_W);

    logic [DIV_W-1:0] cnt_q;
    logic [IDX_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + 1'b1;
    end

    assign sel    = IDX_W'(rate_bit(rate_i, DIV_W));
    assign wave_o = cnt_q[sel];
endmodule

// File: rtl/alm_ctl.sv
module alm_ctl
    import alm_ctl_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick_i,
    input  logic              ref_tick_i,
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] alm1_i,
    input  logic [TIME_W-1:0] alm2_i,
    input  logic [1:0]        alm_ie_i,
    input  logic              intcn_i,
    input  logic [1:0]        rate_i,
    input  logic              stat_wr_i,
    input  logic [1:0]        stat_wdata_i,
    output logic [1:0]        flag_o,
    output logic              pin_o
);
    tod_t                now_t;
    tod_t                alm_t [N_ALARMS];
    logic [N_ALARMS-1:0] hit;
    logic [N_ALARMS-1:0] flags;
    logic                irq_req;
    logic                wave;

    assign now_t    = tod_t'(now_i);
    assign alm_t[0] = tod_t'(alm1_i);
    assign alm_t[1] = tod_t'(alm2_i);

    for (genvar i = 0; i < N_ALARMS; i++) begin : g_alarm
        alm_match u_match (
            .now_i   (now_t),
            .alarm_i (alm_t[i]),
            .hit_o   (hit[i])
        );
        alm_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (sec_tick_i & hit[i]),
            .clr_i  (stat_wr_i & ~stat_wdata_i[i]),
            .flag_o (flags[i])
        );
    end

    sqw_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .step_i (ref_tick_i),
        .rate_i (sqw_rate_e'(rate_i)),
        .wave_o (wave)
    );

    assign irq_req = |(flags & alm_ie_i);
    assign pin_o   = intcn_i ? ~irq_req : wave;
    assign flag_o  = flags;
endmodule

// File: rtl/alm_ctl_chk.sv
module alm_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        sec_tick_i,
    input logic [31:0] now_i,
    input logic [31:0] alm1_i,
    input logic [31:0] alm2_i,
    input logic [1:0]  alm_ie_i,
    input logic        intcn_i,
    input logic        stat_wr_i,
    input logic [1:0]  stat_wdata_i,
    input logic [1:0]  flag_o,
    input logic        pin_o
);
    // R2
    a1_set_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick_i && now_i == alm1_i) |=> flag_o[0]);

    // R3
    a2_set_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick_i && now_i == alm2_i) |=> flag_o[1]);

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o[0]) |-> $past(sec_tick_i));

    // R5
    host_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr_i && !stat_wdata_i[0] && !sec_tick_i) |=> !flag_o[0]);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o[1] && !(stat_wr_i && !stat_wdata_i[1])) |=> flag_o[1]);

    // R8
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (intcn_i && (|(flag_o & alm_ie_i))) |-> !pin_o);

    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (rst)
        (intcn_i && !(|(flag_o & alm_ie_i))) |-> pin_o);
endmodule

bind alm_ctl alm_ctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sec_tick_i   (sec_tick_i),
    .now_i        (now_i),
    .alm1_i       (alm1_i),
    .alm2_i       (alm2_i),
    .alm_ie_i     (alm_ie_i),
    .intcn_i      (intcn_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .flag_o       (flag_o),
    .pin_o        (pin_o)
);

// File: tb/alm_ctl_test.sv
module alm_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick_i = 1'b0;
    logic        ref_tick_i = 1'b0;
    logic [31:0] now_i = '0;
    logic [31:0] alm1_i = 32'hFFFF_FFFF;
    logic [31:0] alm2_i = 32'hFFFF_FFFF;
    logic [1:0]  alm_ie_i = 2'b00;
    logic        intcn_i = 1'b1;
    logic [1:0]  rate_i = 2'b00;
    logic        stat_wr_i = 1'b0;
    logic [1:0]  stat_wdata_i = 2'b11;
    logic [1:0]  flag_o;
    logic        pin_o;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;
    logic [15:0] ref_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alm_ctl uut (
        .clk(clk), .rst(rst), .sec_tick_i(sec_tick_i), .ref_tick_i(ref_tick_i),
        .now_i(now_i), .alm1_i(alm1_i), .alm2_i(alm2_i), .alm_ie_i(alm_ie_i),
        .intcn_i(intcn_i), .rate_i(rate_i), .stat_wr_i(stat_wr_i),
        .stat_wdata_i(stat_wdata_i), .flag_o(flag_o), .pin_o(pin_o)
    );

    // bench reference count of reference ticks
    always @(posedge clk) begin
        if (rst)             ref_cnt <= '0;
        else if (ref_tick_i) ref_cnt <= ref_cnt + 16'd1;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    function automatic logic [7:0] bcd(int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic [31:0] mk_time(int k);
        return {bcd(k % 7 + 1), bcd((k * 5) % 24), bcd((k * 13) % 60), bcd((k * 17 + 3) % 60)};
    endfunction

    task automatic tick();
        @(negedge clk); sec_tick_i = 1'b1;
        @(negedge clk); sec_tick_i = 1'b0;
    endtask

    task automatic wr_stat(logic [1:0] d);
        @(negedge clk); stat_wr_i = 1'b1; stat_wdata_i = d;
        @(negedge clk); stat_wr_i = 1'b0; stat_wdata_i = 2'b11;
    endtask

    task automatic set_flags(logic [1:0] f);
        logic [31:0] t;
        t = mk_time(9);
        wr_stat(2'b00);
        now_i  = t;
        alm1_i = f[0] ? t : t ^ 32'h1;
        alm2_i = f[1] ? t : t ^ 32'h1;
        tick();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] t;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 flags in reset", 32'(flag_o), 0);
        chk("R1 pin in reset", 32'(pin_o), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 flags after reset", 32'(flag_o), 0);
        chk("R1 pin after reset", 32'(pin_o), 1);

        // R2 / R3 / R4: sweep times, full match and single-field mismatch
        for (int k = 0; k < 8; k++) begin
            t = mk_time(k);
            wr_stat(2'b00);
            now_i = t; alm1_i = t; alm2_i = t ^ 32'h0000_0100;
            repeat (2) @(negedge clk);
            chk("R4 equal without tick", 32'(flag_o), 0);
            tick();
            chk("R2 alarm1 match sets", 32'(flag_o[0]), 1);
            chk("R3 alarm2 unaffected", 32'(flag_o[1]), 0);
            wr_stat(2'b00);
            alm2_i = t; alm1_i = t ^ 32'h0001_0000;
            tick();
            chk("R3 alarm2 match sets", 32'(flag_o[1]), 1);
            chk("R3 alarm1 unaffected", 32'(flag_o[0]), 0);
            for (int f = 0; f < 4; f++) begin
                wr_stat(2'b00);
                alm1_i = t ^ (32'h1 << (8 * f));
                alm2_i = t ^ (32'h10 << (8 * f));
                tick();
                chk("R2 field mismatch no set", 32'(flag_o[0]), 0);
                chk("R3 field mismatch no set", 32'(flag_o[1]), 0);
            end
        end

        // R7 sticky across non-matching ticks
        set_flags(2'b11);
        now_i = now_i + 32'h1;
        tick(); tick();
        chk("R7 flags held", 32'(flag_o), 3);

        // R5 write semantics
        wr_stat(2'b11);
        chk("R5 write ones keeps set", 32'(flag_o), 3);
        wr_stat(2'b10);
        chk("R5 write zero clears bit0 only", 32'(flag_o), 2);
        wr_stat(2'b11);
        chk("R5 write one does not set", 32'(flag_o), 2);
        wr_stat(2'b01);
        chk("R5 write zero clears bit1", 32'(flag_o), 0);

        // R6 set and clear on the same edge, from clear and from set
        for (int p = 0; p < 2; p++) begin
            t = mk_time(3);
            now_i = t; alm1_i = t; alm2_i = t ^ 32'h1;
            @(negedge clk);
            sec_tick_i = 1'b1; stat_wr_i = 1'b1; stat_wdata_i = 2'b00;
            @(negedge clk);
            sec_tick_i = 1'b0; stat_wr_i = 1'b0; stat_wdata_i = 2'b11;
            chk("R6 set wins over clear", 32'(flag_o[0]), 1);
            chk("R6 other flag cleared", 32'(flag_o[1]), 0);
        end

        // R8 exhaustive flags x enables in interrupt mode
        intcn_i = 1'b1;
        for (int f = 0; f < 4; f++) begin
            set_flags(2'(f));
            for (int e = 0; e < 4; e++) begin
                @(negedge clk); alm_ie_i = 2'(e);
                @(negedge clk);
                chk("R8 interrupt pin", 32'(pin_o), ((f & e) != 0) ? 0 : 1);
            end
        end

        // R9 square-wave mode: flags/enables ignored, frozen count
        set_flags(2'b11);
        alm_ie_i = 2'b11;
        intcn_i  = 1'b0;
        for (int r = 0; r < 4; r++) begin
            @(negedge clk); rate_i = 2'(r);
            @(negedge clk);
            chk("R9 pin ignores flags", 32'(pin_o), 0);
        end

        // R9 running divider, every rate
        ref_tick_i = 1'b1;
        for (int r = 3; r >= 0; r--) begin
            int idx;
            idx = (r == 0) ? 15 : (r == 1) ? 3 : (r == 2) ? 2 : 0;
            rate_i = 2'(r);
            for (int c = 0; c < ((r == 0) ? 70000 : 64); c++) begin
                @(negedge clk);
                chk("R9 square wave", 32'(pin_o), 32'(ref_cnt[idx]));
            end
        end
        ref_tick_i = 1'b0;

        // back to interrupt mode with flags set
        intcn_i = 1'b1;
        @(negedge clk);
        chk("R8 pin low after mode return", 32'(pin_o), 0);

        summary();
    end
endmodule